// File: doc/BRIEF.md
# SPI Status Flag Controller with Debug-Break Protection

This block holds the status and control flag logic for an SPI peripheral. It keeps three flags: transmit buffer empty, receive buffer full and receive overflow. It accepts qualified register strobes from the CPU bus decode and decides whether a data-register write may load the transmit buffer. It turns a buffered byte into a one-cycle start request for the shift register and turns a shift-register completion into receive-full or overflow. It also raises one registered interrupt request per flag.

Receive-full and overflow are cleared in two steps. First a status read has to see the flag set, which arms a per-flag memory bit. Then a data read completes the clear. A debug-break input, together with a break-clear-enable input, decides whether software clear sequences take effect while the break lasts. With clearing protected, every status read, data read and data write made during the break is ignored, and an armed bit set before the break survives it.

There is a low-power interface as well. In wait mode the logic keeps running and interrupts keep asserting, but CPU accesses are refused. In stop mode all state is frozen until the mode ends. A synchronous reset returns everything to its initial state, and in stop mode it also drops any transfer in progress.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After a reset cycle, `stat_o` is 3'b001, `irq_o` and `wake_o` are 0 and no transfer start is issued. `stat_o` bit 0 is transmit-empty, bit 1 is receive-full and bit 2 is overflow. All interrupt enables are 0.
- R2: An accepted data write with transmit-empty at 1 loads `wdata_i` into the transmit buffer and clears transmit-empty at that clock edge. A data write while transmit-empty is 0 is ignored.
- R3: When transmit-empty is 0 and no transfer is busy, the next edge raises `xfer_start_o` for exactly one cycle, presents the buffered byte on `xfer_tx_o`, marks the shifter busy and sets transmit-empty to 1.
- R4: `xfer_done_i` while busy ends the transfer. If receive-full was 0, it sets receive-full and captures `xfer_rx_i` into `rdata_o`. If receive-full was 1, it sets overflow and leaves `rdata_o` unchanged. `xfer_done_i` while not busy is ignored.
- R5: Two-step clear. A status read arms receive-full and overflow, each arming only if its flag is 1 and each disarming if its flag is 0. A later data read clears each armed flag and consumes the arming. A status read and a data read in the same cycle clear nothing. A flag being set by hardware wins over a clear in the same cycle.
- R6: With `brk_i` at 1 and `brk_clr_en_i` at 0, status reads, data reads and data writes change no flag and no armed bit. A data write neither loads the buffer nor starts a transfer.
- R7: An arming made before a protected break is kept through it. A data read after the break ends completes the clear.
- R8: With `brk_i` at 1 and `brk_clr_en_i` at 1, two-step clears work as in R5, and a flag cleared this way stays 0 after the break ends.
- R9: `irq_o[i]` equals flag bit i ANDed with enable bit i, registered one cycle later. The enables are loaded from `ctrl_i` by an accepted `ctrl_wr_i`: bit 0 enables transmit-empty, bit 1 enables receive-full and bit 2 enables overflow. A control write is accepted during a break.
- R10: With `wait_i` at 1, every register strobe is ignored while transfers, flag setting and interrupts continue. `wake_o` is registered and is 1 one cycle after `wait_i` was 1 while any enabled flag was set.
- R11: With `stop_i` at 1, flags, buffers, enables and armed bits hold, strobes and `xfer_done_i` are ignored and no start is issued. Operation resumes when `stop_i` returns to 0.
- R12: A reset applied during stop aborts a pending transfer. A later `xfer_done_i` then has no effect, and the flags read 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Stop mode: freeze all state |
| wait_i | input | 1 | Wait mode: refuse CPU accesses, keep running |
| brk_i | input | 1 | Debug break state |
| brk_clr_en_i | input | 1 | Allow flag clearing during break |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| wdata_i | input | DW | Data register write value |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_i | input | 3 | Interrupt enables {overflow, receive-full, transmit-empty} |
| xfer_done_i | input | 1 | Shift register finished a transfer |
| xfer_rx_i | input | DW | Byte received by the shift register |
| stat_o | output | 3 | Flags {overflow, receive-full, transmit-empty} |
| rdata_o | output | DW | Receive buffer |
| xfer_start_o | output | 1 | One-cycle transfer start request |
| xfer_tx_o | output | DW | Byte to shift out |
| irq_o | output | 3 | Interrupt requests {overflow, receive-full, transmit-empty} |
| wake_o | output | 1 | Wake request while in wait mode |

## Verification
The hardest case to reach is a two-step clear split across a protected break. The status read has to arm the flag before the break, the data read during the break has to be held off, and the clear has to complete only once the break ends. A directed sequence builds receive-full through a full write, start and done handshake, arms it, raises the break and then steps through reads on both sides of the break edge. The same ground is then covered at random: break, clear-enable, wait and stop are toggled rarely while strobes and completions arrive densely, so that arming, blocking and hardware setting of the flags keep overlapping.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int NFLAG = 3;
  localparam int F_TXE = 0;
  localparam int F_RXF = 1;
  localparam int F_OVF = 2;
  localparam int NARM  = 2;

  typedef struct packed {
    logic stat_rd;
    logic data_rd;
    logic data_wr;
    logic ctrl_wr;
  } acc_t;
endpackage

// File: rtl/spi_flag_gate.sv
module spi_flag_gate
  import spi_flag_pkg::*;
(
  input  logic stop_i,
  input  logic wait_i,
  input  logic brk_i,
  input  logic brk_clr_en_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  input  logic data_wr_i,
  input  logic ctrl_wr_i,
  output logic run_o,
  output acc_t acc_o
);
  logic cpu_ok;
  logic clr_ok;

  // CPU accesses are refused in both low-power modes
  assign cpu_ok = ~stop_i & ~wait_i;
  // flag-touching accesses are held off in a protected break
  assign clr_ok = ~brk_i | brk_clr_en_i;
  assign run_o  = ~stop_i;

  always_comb begin
    acc_o.stat_rd = stat_rd_i & cpu_ok & clr_ok;
    acc_o.data_rd = data_rd_i & cpu_ok & clr_ok;
    acc_o.data_wr = data_wr_i & cpu_ok & clr_ok;
    acc_o.ctrl_wr = ctrl_wr_i & cpu_ok;
  end
endmodule

// File: rtl/spi_flag_arm.sv
module spi_flag_arm (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  input  logic flag_i,
  output logic clr_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (stat_rd_i) begin
      armed_q <= flag_i;
    end else if (data_rd_i) begin
      armed_q <= 1'b0;
    end
  end

  assign clr_o = data_rd_i & ~stat_rd_i & armed_q;
endmodule

// File: rtl/spi_flag_tx.sv
module spi_flag_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  output logic          txe_o,
  output logic          busy_o,
  output logic          start_o,
  output logic [DW-1:0] tx_o
);
  logic [DW-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      txe_o   <= 1'b1;
      busy_o  <= 1'b0;
      start_o <= 1'b0;
      tx_o    <= '0;
      buf_q   <= '0;
    end else if (!run_i) begin
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (done_i && busy_o) begin
        busy_o <= 1'b0;
      end
      if (!txe_o && !busy_o) begin
        start_o <= 1'b1;
        tx_o    <= buf_q;
        busy_o  <= 1'b1;
        txe_o   <= 1'b1;
      end else if (wr_i && txe_o) begin
        buf_q <= wdata_i;
        txe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_flag_rx.sv
module spi_flag_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fin_i,
  input  logic [DW-1:0] rx_i,
  input  logic          clr_rxf_i,
  input  logic          clr_ovf_i,
  output logic          rxf_o,
  output logic          ovf_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rxf_o   <= 1'b0;
      ovf_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (fin_i && !rxf_o) begin
        rxf_o   <= 1'b1;
        rdata_o <= rx_i;
      end else if (clr_rxf_i) begin
        rxf_o <= 1'b0;
      end
      if (fin_i && rxf_o) begin
        ovf_o <= 1'b1;
      end else if (clr_ovf_i) begin
        ovf_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_flag_irq.sv
module spi_flag_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctrl_wr_i,
  input  logic [N-1:0] ctrl_i,
  input  logic [N-1:0] flags_i,
  input  logic         wait_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] irq_o,
  output logic         wake_o
);
  logic [N-1:0] req;

  assign req = flags_i & en_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o <= '0;
    end else if (ctrl_wr_i) begin
      en_o <= ctrl_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irq_o[i] <= 1'b0;
      end else begin
        irq_o[i] <= req[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_o <= 1'b0;
    end else begin
      wake_o <= wait_i & (|req);
    end
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop_i,
  input  logic          wait_i,
  input  logic          brk_i,
  input  logic          brk_clr_en_i,
  input  logic          stat_rd_i,
  input  logic          data_rd_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ctrl_wr_i,
  input  logic [2:0]    ctrl_i,
  input  logic          xfer_done_i,
  input  logic [DW-1:0] xfer_rx_i,
  output logic [2:0]    stat_o,
  output logic [DW-1:0] rdata_o,
  output logic          xfer_start_o,
  output logic [DW-1:0] xfer_tx_o,
  output logic [2:0]    irq_o,
  output logic          wake_o
);
  acc_t            acc;
  logic            run;
  logic            txe;
  logic            rxf;
  logic            ovf;
  logic            tx_busy;
  logic            fin;
  logic [NARM-1:0] arm_flag;
  logic [NARM-1:0] arm_clr;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] irq_en;

  spi_flag_gate u_gate (
    .stop_i       (stop_i),
    .wait_i       (wait_i),
    .brk_i        (brk_i),
    .brk_clr_en_i (brk_clr_en_i),
    .stat_rd_i    (stat_rd_i),
    .data_rd_i    (data_rd_i),
    .data_wr_i    (data_wr_i),
    .ctrl_wr_i    (ctrl_wr_i),
    .run_o        (run),
    .acc_o        (acc)
  );

  spi_flag_tx #(.DW(DW)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .wr_i    (acc.data_wr),
    .wdata_i (wdata_i),
    .done_i  (xfer_done_i),
    .txe_o   (txe),
    .busy_o  (tx_busy),
    .start_o (xfer_start_o),
    .tx_o    (xfer_tx_o)
  );

  assign fin = run & xfer_done_i & tx_busy;

  // index 0: receive-full, index 1: overflow
  assign arm_flag = {ovf, rxf};

  for (genvar k = 0; k < NARM; k++) begin : g_arm
    spi_flag_arm u_arm (
      .clk       (clk),
      .rst       (rst),
      .stat_rd_i (acc.stat_rd),
      .data_rd_i (acc.data_rd),
      .flag_i    (arm_flag[k]),
      .clr_o     (arm_clr[k])
    );
  end

  spi_flag_rx #(.DW(DW)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .fin_i     (fin),
    .rx_i      (xfer_rx_i),
    .clr_rxf_i (arm_clr[0]),
    .clr_ovf_i (arm_clr[1]),
    .rxf_o     (rxf),
    .ovf_o     (ovf),
    .rdata_o   (rdata_o)
  );

  always_comb begin
    flags        = '0;
    flags[F_TXE] = txe;
    flags[F_RXF] = rxf;
    flags[F_OVF] = ovf;
  end

  assign stat_o = flags;

  spi_flag_irq #(.N(NFLAG)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr_i (acc.ctrl_wr),
    .ctrl_i    (ctrl_i),
    .flags_i   (flags),
    .wait_i    (wait_i),
    .en_o      (irq_en),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          stop_i,
  input logic          wait_i,
  input logic          brk_i,
  input logic          brk_clr_en_i,
  input logic          xfer_done_i,
  input logic [2:0]    stat_o,
  input logic [DW-1:0] rdata_o,
  input logic          xfer_start_o,
  input logic [2:0]    irq_o,
  input logic          wake_o,
  input logic [2:0]    irq_en
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stat_o == 3'b001 && irq_o == 3'b000 && !xfer_start_o && !wake_o));

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_start_o |=> !xfer_start_o);

  p_ovf_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o[2]) |-> $past(xfer_done_i && stat_o[1]));

  p_brk_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (brk_i && !brk_clr_en_i) |=> (!$fell(stat_o[0]) && !$fell(stat_o[1]) && !$fell(stat_o[2])));

  p_err_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_o[2] && irq_en[2]) |=> irq_o[2]);

  p_err_mask_r9: assert property (@(posedge clk) disable iff (rst)
    !irq_en[2] |=> !irq_o[2]);

  p_wait_noclr_r10: assert property (@(posedge clk) disable iff (rst)
    wait_i |=> (!$fell(stat_o[0]) && !$fell(stat_o[1]) && !$fell(stat_o[2])));

  p_wake_r10: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(wait_i));

  p_stop_hold_r11: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> ($stable(stat_o) && $stable(rdata_o) && !xfer_start_o));
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/spi_flag_ctrl_bench.sv
module spi_flag_ctrl_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b0;
  logic          stop_r = 1'b0, wait_r = 1'b0, brk_r = 1'b0, bce_r = 1'b0;
  logic          stat_rd = 1'b0, data_rd = 1'b0, data_wr = 1'b0, ctrl_wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [2:0]    ctrl = '0;
  logic          xfer_done = 1'b0;
  logic [DW-1:0] xfer_rx = '0;
  logic [2:0]    stat;
  logic [DW-1:0] rdata;
  logic          xstart;
  logic [DW-1:0] xtx;
  logic [2:0]    irq;
  logic          wake;

  int nchk = 0;
  int nerr = 0;

  // reference state
  logic m_txe, m_rxf, m_ovf, m_arx, m_aov, m_busy, m_start, m_wake;
  logic [DW-1:0] m_buf, m_tx, m_rdata;
  logic [2:0] m_en, m_irq;

  always #4 clk = ~clk;

  spi_flag_ctrl #(.DW(DW)) u_spi_flag_ctrl (
    .clk(clk), .rst(rst), .stop_i(stop_r), .wait_i(wait_r), .brk_i(brk_r),
    .brk_clr_en_i(bce_r), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .data_wr_i(data_wr), .wdata_i(wdata), .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl),
    .xfer_done_i(xfer_done), .xfer_rx_i(xfer_rx), .stat_o(stat),
    .rdata_o(rdata), .xfer_start_o(xstart), .xfer_tx_o(xtx), .irq_o(irq),
    .wake_o(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [2:0] o_fl;
    logic cpu, ok, sr, dr, dw, cw, fin, clr_rx, clr_ov, o_busy, o_rxf;
    if (rst) begin
      m_txe = 1; m_rxf = 0; m_ovf = 0; m_arx = 0; m_aov = 0; m_busy = 0;
      m_start = 0; m_wake = 0; m_buf = '0; m_tx = '0; m_rdata = '0;
      m_en = '0; m_irq = '0;
    end else begin
      o_fl = {m_ovf, m_rxf, m_txe};
      m_irq = o_fl & m_en;
      m_wake = wait_r && (|(o_fl & m_en));
      if (stop_r) begin
        m_start = 0;
      end else begin
        cpu = !wait_r;
        ok = cpu && (!brk_r || bce_r);
        sr = ok && stat_rd; dr = ok && data_rd; dw = ok && data_wr;
        cw = cpu && ctrl_wr;
        fin = xfer_done && m_busy;
        clr_rx = dr && !sr && m_arx;
        clr_ov = dr && !sr && m_aov;
        if (sr) begin m_arx = m_rxf; m_aov = m_ovf; end
        else if (dr) begin m_arx = 0; m_aov = 0; end
        o_busy = m_busy;
        m_start = 0;
        if (fin) m_busy = 0;
        if (!m_txe && !o_busy) begin
          m_start = 1; m_tx = m_buf; m_busy = 1; m_txe = 1;
        end else if (dw && m_txe) begin
          m_buf = wdata; m_txe = 0;
        end
        o_rxf = m_rxf;
        if (fin && !o_rxf) begin m_rxf = 1; m_rdata = xfer_rx; end
        else if (clr_rx) m_rxf = 0;
        if (fin && o_rxf) m_ovf = 1;
        else if (clr_ov) m_ovf = 0;
        if (cw) m_en = ctrl;
      end
    end
  endtask

  task automatic compare_all();
    check("R2 transmit-empty", stat[0], m_txe);
    check("R4 receive-full", stat[1], m_rxf);
    check("R5 overflow", stat[2], m_ovf);
    check("R4 receive data", rdata, m_rdata);
    check("R3 start pulse", xstart, m_start);
    if (m_start) check("R3 start data", xtx, m_tx);
    check("R9 irq lines", irq, m_irq);
    check("R10 wake", wake, m_wake);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    stat_rd = 0; data_rd = 0; data_wr = 0; ctrl_wr = 0; xfer_done = 0; rst = 0;
  endtask

  // write a byte, let it start, then complete with a received byte
  task automatic make_rx(input logic [DW-1:0] b);
    data_wr = 1; wdata = b; tick();
    tick();
    tick();
    xfer_done = 1; xfer_rx = b; tick();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5A17);
    @(negedge clk);
    rst = 1; tick();
    check("R1 reset flags", stat, 3'b001);
    check("R1 reset irq", irq, 3'b000);
    check("R1 reset start", xstart, 1'b0);

    // enable all interrupts
    ctrl_wr = 1; ctrl = 3'b111; tick(); tick();
    check("R9 txe irq", irq, 3'b001);

    // R6: protected break ignores reads and writes
    make_rx(8'hA5);
    check("R4 rx captured", rdata, 8'hA5);
    brk_r = 1; bce_r = 0;
    stat_rd = 1; tick();
    data_rd = 1; tick();
    check("R6 rxf held in break", stat[1], 1'b1);
    data_wr = 1; wdata = 8'h11; tick();
    check("R6 write ignored txe", stat[0], 1'b1);
    tick(); tick();
    check("R6 no start from write", xstart, 1'b0);
    brk_r = 0;
    data_rd = 1; tick();
    check("R6 no arming during break", stat[1], 1'b1);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    check("R5 two-step clear", stat[1], 1'b0);

    // R7: arming before a protected break is kept
    make_rx(8'h5C);
    stat_rd = 1; tick();
    brk_r = 1; bce_r = 0;
    data_rd = 1; tick();
    check("R7 held during break", stat[1], 1'b1);
    brk_r = 0;
    data_rd = 1; tick();
    check("R7 completes after break", stat[1], 1'b0);

    // R8: clear-enabled break
    make_rx(8'h77);
    brk_r = 1; bce_r = 1;
    stat_rd = 1; tick();
    data_rd = 1; tick();
    check("R8 cleared in break", stat[1], 1'b0);
    brk_r = 0; bce_r = 0; tick();
    check("R8 stays cleared", stat[1], 1'b0);

    // R11: stop freezes a pending transfer
    data_wr = 1; wdata = 8'h3C; tick(); tick(); tick();
    stop_r = 1;
    xfer_done = 1; xfer_rx = 8'h3C; tick();
    check("R11 done ignored in stop", stat[1], 1'b0);
    stat_rd = 1; tick(); tick();
    stop_r = 0;
    xfer_done = 1; xfer_rx = 8'h3C; tick(); tick();
    check("R11 resumes after stop", stat[1], 1'b1);
    check("R11 data after stop", rdata, 8'h3C);
    stat_rd = 1; tick(); data_rd = 1; tick();

    // R12: reset during stop aborts transfer
    data_wr = 1; wdata = 8'h99; tick(); tick(); tick();
    stop_r = 1; rst = 1; tick();
    check("R12 reset in stop", stat, 3'b001);
    stop_r = 0;
    xfer_done = 1; xfer_rx = 8'h99; tick(); tick();
    check("R12 aborted transfer", stat, 3'b001);

    // R10: wait mode ignores accesses, keeps interrupts
    ctrl_wr = 1; ctrl = 3'b110; tick();
    make_rx(8'h42);
    wait_r = 1;
    stat_rd = 1; tick(); data_rd = 1; tick(); tick();
    check("R10 access ignored in wait", stat[1], 1'b1);
    check("R10 wake asserted", wake, 1'b1);
    wait_r = 0; tick();

    // constrained random phase
    for (int c = 0; c < 6000; c++) begin
      stat_rd   = ($urandom % 100) < 25;
      data_rd   = ($urandom % 100) < 20;
      data_wr   = ($urandom % 100) < 15;
      wdata     = DW'($urandom);
      ctrl_wr   = ($urandom % 100) < 5;
      ctrl      = 3'($urandom);
      xfer_done = ($urandom % 100) < 20;
      xfer_rx   = DW'($urandom);
      if (($urandom % 100) < 3) begin brk_r = ~brk_r; bce_r = 1'($urandom); end
      if (($urandom % 100) < 2) wait_r = ~wait_r;
      if (($urandom % 1000) < 8) stop_r = ~stop_r;
      rst = ($urandom % 1000) < 3;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule